// File: doc/BRIEF.md
# Block-Edge Deblocking Decision and Narrow Filter

This block takes one line of eight unsigned pixels that straddles a block edge, four on each side, together with three per-line thresholds: an edge limit, an interior limit and a variance threshold. It decides whether the edge should be smoothed at all, whether activity next to the edge is high, and whether both sides are flat enough to be handed to a wider smoothing stage downstream. It then applies the narrow correction, which moves at most the two pixels nearest the edge on each side.

Lines arrive on a valid/ready stream and leave on a second valid/ready stream, one line per cycle, through a two-stage pipeline. The whole pipeline advances only when its output register is empty or the consumer takes the output. `in_ready` is therefore high exactly when `out_valid` is low or `out_ready` is high. A line with `in_valid` high is accepted on a rising edge where `in_ready` is high. A presented output holds every output bit until it is taken. A mode pin chosen per line selects the four-wide variant. In that variant the flatness decision is suppressed, so the narrow filter always acts wherever the edge decision passes.

Top module: `dbf_edge_filter`

## Requirements
- R1: A line is packed one byte per pixel: byte 0 is p3, byte 1 is p2, byte 2 is p1, byte 3 is p0, byte 4 is q0, byte 5 is q1, byte 6 is q2 and byte 7 is q3. An accepted line appears on `out_line` with its flags two rising edges later when `out_ready` stays high. Back-to-back lines leave one per cycle, in order.
- R2: `out_mask` is 1 when two conditions both hold. The first is that the largest absolute difference between neighbours on the same side (p3/p2, p2/p1, p1/p0, q0/q1, q1/q2, q2/q3) is no greater than `lim_inner`. The second is that min(255, 2*|p0-q0|) + (|p1-q1|>>1), saturated at 255, is no greater than `lim_edge`.
- R3: `out_hev` is 1 when max(|p1-p0|, |q1-q0|) is greater than `thr_var`. This holds whatever the mask.
- R4: With `narrow_only` low, `out_flat` is 1 when the mask holds and each of |p3-p0|, |p2-p0|, |p1-p0|, |q1-q0|, |q2-q0| and |q3-q0| is at most 1.
- R5: With `narrow_only` high, `out_flat` is 0 and the narrow filter applies under the mask alone.
- R6: When the mask holds and `out_flat` is 0, the filter value is formed as follows. f = clamp(-128..127, 3*(q0-p0) + t), where t = clamp(-128..127, p1-q1) if hev and t = 0 otherwise. Then f1 = clamp(f+4)>>>3 and f2 = clamp(f+3)>>>3. The outputs are p0' = clamp(0..255, p0+f2) and q0' = clamp(0..255, q0-f1).
- R7: p1 and q1 change only when the mask holds, `out_flat` is 0 and hev is 0. In that case g = (f1+1)>>>1, p1' = clamp(0..255, p1+g) and q1' = clamp(0..255, q1-g).
- R8: When the mask is 0, all eight pixels leave unchanged. p3, p2, q2 and q3 always leave unchanged.
- R9: When `out_flat` is 1, all eight pixels leave unchanged, for the downstream smoothing stage.
- R10: While `out_valid` is high and `out_ready` is low, every output holds its value and `in_ready` is low. Lines then drain in order once `out_ready` rises.
- R11: During reset `out_valid` is 0. After reset, `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input line present |
| in_ready | output | 1 | Pipeline can take a line this cycle |
| in_line | input | 64 | Eight pixels, byte order per R1 |
| lim_edge | input | 8 | Edge limit for the mask, taken with the line |
| lim_inner | input | 8 | Interior limit for the mask, taken with the line |
| thr_var | input | 8 | High-variance threshold, taken with the line |
| narrow_only | input | 1 | Four-wide variant: suppress flatness, taken with the line |
| out_valid | output | 1 | Output line present |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_line | output | 64 | Filtered pixels, byte order per R1 |
| out_mask | output | 1 | Edge decision for this line |
| out_hev | output | 1 | High-variance flag for this line |
| out_flat | output | 1 | Flat flag for the downstream stage |

## Verification
The decision flags are registered in the first stage and travel beside the pixels. A corrupted flag or threshold compare therefore shows up two cycles after acceptance, as a wrong flag together with pixels that were changed or left alone against the rules: the inner pair moves when a flat or masked-off line should pass through, or p1/q1 move on a high-variance line. A wrong clamp or shift shows as an off-by-some inner pixel on the same output beat. A stall fault shows as an output that changes, or a line that is lost or duplicated, during the cycles that `out_ready` is held low.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

  // Per-line decision flags carried beside the pixels through the pipe.
  typedef struct packed {
    logic mask;   // edge is to be filtered
    logic hev;    // high activity next to the edge
    logic flat;   // flat on both sides and masked (left to wide stage)
  } dbf_flags_t;

  localparam int unsigned FLAG_W = 3;

  // Extra bits above the pixel width for signed filter arithmetic.
  localparam int unsigned GUARD_W = 4;

endpackage

// File: rtl/dbf_stage_reg.sv
module dbf_stage_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         d_vld,
  input  logic [W-1:0] d,
  output logic         q_vld,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld <= 1'b0;
    end else if (adv) begin
      q_vld <= d_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      q <= d;
    end
  end

endmodule

// File: rtl/dbf_mask.sv
module dbf_mask
  import dbf_pkg::*;
#(
  parameter int unsigned PIX_W    = 8,
  parameter int unsigned TAPS     = 4,
  parameter int unsigned FLAT_THR = 1
) (
  input  logic [2*TAPS*PIX_W-1:0] line,
  input  logic [PIX_W-1:0]        lim_e,
  input  logic [PIX_W-1:0]        lim_i,
  input  logic [PIX_W-1:0]        thr_h,
  input  logic                    narrow,
  output dbf_flags_t              flags
);

  localparam int unsigned NPIX = 2 * TAPS;
  localparam int unsigned IP0  = TAPS - 1;   // p0 position
  localparam int unsigned IQ0  = TAPS;       // q0 position
  localparam logic [PIX_W-1:0] FLAT_LIM = PIX_W'(FLAT_THR);

  function automatic logic [PIX_W-1:0] absd(input logic [PIX_W-1:0] a,
                                             input logic [PIX_W-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  logic [PIX_W-1:0] px [NPIX];

  for (genvar k = 0; k < NPIX; k++) begin : g_unpack
    assign px[k] = line[k*PIX_W +: PIX_W];
  end

  // Neighbour differences on each side; the pair across the edge is skipped.
  logic [PIX_W-1:0] nb [NPIX-1];
  for (genvar k = 0; k < NPIX - 1; k++) begin : g_nb
    if (k == IP0) begin : g_cross
      assign nb[k] = '0;
    end else begin : g_side
      assign nb[k] = absd(px[k], px[k+1]);
    end
  end

  // Distances from the edge pixel of each side, for flatness.
  logic [TAPS-2:0] fp_ok;
  logic [TAPS-2:0] fq_ok;
  for (genvar k = 0; k < TAPS - 1; k++) begin : g_flat
    assign fp_ok[k] = absd(px[k], px[IP0]) <= FLAT_LIM;
    assign fq_ok[k] = absd(px[IQ0+1+k], px[IQ0]) <= FLAT_LIM;
  end

  logic [PIX_W-1:0] inner_max;
  logic [PIX_W-1:0] d_edge;
  logic [PIX_W-1:0] d_outer;
  logic [PIX_W-1:0] dbl_sat;
  logic [PIX_W:0]   edge_sum;
  logic [PIX_W-1:0] edge_val;
  logic [PIX_W-1:0] act_p;
  logic [PIX_W-1:0] act_q;
  logic             flat_raw;

  always_comb begin
    inner_max = '0;
    for (int k = 0; k < int'(NPIX) - 1; k++) begin
      if (nb[k] > inner_max) inner_max = nb[k];
    end

    d_edge   = absd(px[IP0], px[IQ0]);
    d_outer  = absd(px[IP0-1], px[IQ0+1]);
    dbl_sat  = d_edge[PIX_W-1] ? '1 : {d_edge[PIX_W-2:0], 1'b0};
    edge_sum = {1'b0, dbl_sat} + {2'b00, d_outer[PIX_W-1:1]};
    edge_val = edge_sum[PIX_W] ? '1 : edge_sum[PIX_W-1:0];

    act_p    = absd(px[IP0-1], px[IP0]);
    act_q    = absd(px[IQ0+1], px[IQ0]);

    flat_raw = (&fp_ok) && (&fq_ok);

    flags.mask = (inner_max <= lim_i) && (edge_val <= lim_e);
    flags.hev  = ((act_p > act_q) ? act_p : act_q) > thr_h;
    flags.flat = flat_raw && !narrow && (inner_max <= lim_i) && (edge_val <= lim_e);
  end

endmodule

// File: rtl/dbf_narrow.sv
module dbf_narrow
  import dbf_pkg::*;
#(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned TAPS  = 4
) (
  input  logic [2*TAPS*PIX_W-1:0] line,
  input  dbf_flags_t              flags,
  output logic [2*TAPS*PIX_W-1:0] line_o
);

  localparam int unsigned SW  = PIX_W + GUARD_W;
  localparam int unsigned OP1 = (TAPS - 2) * PIX_W;
  localparam int unsigned OP0 = (TAPS - 1) * PIX_W;
  localparam int unsigned OQ0 = TAPS * PIX_W;
  localparam int unsigned OQ1 = (TAPS + 1) * PIX_W;

  localparam int SMAX_I = (2 ** (PIX_W - 1)) - 1;
  localparam int SMIN_I = -(2 ** (PIX_W - 1));
  localparam int UMAX_I = (2 ** PIX_W) - 1;

  localparam logic signed [SW-1:0] S_MAX = SW'(SMAX_I);
  localparam logic signed [SW-1:0] S_MIN = SW'(SMIN_I);
  localparam logic signed [SW-1:0] U_MAX = SW'(UMAX_I);
  localparam logic signed [SW-1:0] C1    = SW'(1);
  localparam logic signed [SW-1:0] C3    = SW'(3);
  localparam logic signed [SW-1:0] C4    = SW'(4);

  function automatic logic signed [SW-1:0] sclamp(input logic signed [SW-1:0] v);
    if (v > S_MAX)      return S_MAX;
    else if (v < S_MIN) return S_MIN;
    else                return v;
  endfunction

  function automatic logic [PIX_W-1:0] uclamp(input logic signed [SW-1:0] v);
    if (v < 0)          return '0;
    else if (v > U_MAX) return '1;
    else                return v[PIX_W-1:0];
  endfunction

  function automatic logic signed [SW-1:0] widen(input logic [PIX_W-1:0] p);
    return $signed({{GUARD_W{1'b0}}, p});
  endfunction

  logic signed [SW-1:0] sp1, sp0, sq0, sq1;
  logic signed [SW-1:0] tap, dq, f, f4, f3, f1, f2, g;

  always_comb begin
    sp1 = widen(line[OP1 +: PIX_W]);
    sp0 = widen(line[OP0 +: PIX_W]);
    sq0 = widen(line[OQ0 +: PIX_W]);
    sq1 = widen(line[OQ1 +: PIX_W]);

    tap = flags.hev ? sclamp(sp1 - sq1) : '0;
    dq  = sq0 - sp0;
    f   = sclamp(dq + dq + dq + tap);
    f4  = sclamp(f + C4);
    f3  = sclamp(f + C3);
    f1  = f4 >>> 3;
    f2  = f3 >>> 3;
    g   = (f1 + C1) >>> 1;

    line_o = line;
    if (flags.mask && !flags.flat) begin
      line_o[OP0 +: PIX_W] = uclamp(sp0 + f2);
      line_o[OQ0 +: PIX_W] = uclamp(sq0 - f1);
      if (!flags.hev) begin
        line_o[OP1 +: PIX_W] = uclamp(sp1 + g);
        line_o[OQ1 +: PIX_W] = uclamp(sq1 - g);
      end
    end
  end

endmodule

// File: rtl/dbf_edge_filter.sv
module dbf_edge_filter
  import dbf_pkg::*;
#(
  parameter int unsigned PIX_W    = 8,
  parameter int unsigned TAPS     = 4,
  parameter int unsigned FLAT_THR = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [2*TAPS*PIX_W-1:0] in_line,
  input  logic [PIX_W-1:0]        lim_edge,
  input  logic [PIX_W-1:0]        lim_inner,
  input  logic [PIX_W-1:0]        thr_var,
  input  logic                    narrow_only,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [2*TAPS*PIX_W-1:0] out_line,
  output logic                    out_mask,
  output logic                    out_hev,
  output logic                    out_flat
);

  localparam int unsigned LINE_W  = 2 * TAPS * PIX_W;
  localparam int unsigned STAGE_W = LINE_W + FLAG_W;

  // One advance for the whole pipe: move when the output slot frees up.
  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // Stage 1: decisions from the raw line.
  dbf_flags_t           flg_d;
  logic                 s1_vld;
  logic [STAGE_W-1:0]   s1_q;
  logic [LINE_W-1:0]    s1_line;
  dbf_flags_t           s1_flg;

  dbf_mask #(.PIX_W(PIX_W), .TAPS(TAPS), .FLAT_THR(FLAT_THR)) u_mask (
    .line   (in_line),
    .lim_e  (lim_edge),
    .lim_i  (lim_inner),
    .thr_h  (thr_var),
    .narrow (narrow_only),
    .flags  (flg_d)
  );

  dbf_stage_reg #(.W(STAGE_W)) u_s1 (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .d_vld (in_valid),
    .d     ({flg_d, in_line}),
    .q_vld (s1_vld),
    .q     (s1_q)
  );

  assign s1_line = s1_q[LINE_W-1:0];
  assign s1_flg  = s1_q[STAGE_W-1:LINE_W];

  // Stage 2: narrow correction.
  logic [LINE_W-1:0]  filt_line;
  logic [STAGE_W-1:0] s2_q;
  dbf_flags_t         s2_flg;

  dbf_narrow #(.PIX_W(PIX_W), .TAPS(TAPS)) u_narrow (
    .line   (s1_line),
    .flags  (s1_flg),
    .line_o (filt_line)
  );

  dbf_stage_reg #(.W(STAGE_W)) u_s2 (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .d_vld (s1_vld),
    .d     ({s1_flg, filt_line}),
    .q_vld (out_valid),
    .q     (s2_q)
  );

  assign out_line = s2_q[LINE_W-1:0];
  assign s2_flg   = s2_q[STAGE_W-1:LINE_W];
  assign out_mask = s2_flg.mask;
  assign out_hev  = s2_flg.hev;
  assign out_flat = s2_flg.flat;

endmodule

// File: rtl/dbf_edge_filter_chk.sv
module dbf_edge_filter_chk #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned TAPS  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [2*TAPS*PIX_W-1:0] in_line,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [2*TAPS*PIX_W-1:0] out_line,
  input logic                    out_mask,
  input logic                    out_hev,
  input logic                    out_flat
);

  localparam int unsigned LINE_W = 2 * TAPS * PIX_W;
  localparam int unsigned LO_W   = (TAPS - 2) * PIX_W;
  localparam int unsigned HI_B   = (TAPS + 2) * PIX_W;
  localparam int unsigned OP1    = (TAPS - 2) * PIX_W;
  localparam int unsigned OQ1    = (TAPS + 1) * PIX_W;

  // Shadow of the unfiltered line, moved with the stream handshake.
  logic              sh_adv;
  logic [LINE_W-1:0] sh1, sh2;
  assign sh_adv = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (sh_adv) begin
      sh1 <= in_line;
      sh2 <= sh1;
    end
  end

  a_r11_reset_idle: assert property (@(posedge clk) !rst_n |=> !out_valid);

  a_r10_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_line) && $stable(out_mask)
                               && $stable(out_hev) && $stable(out_flat));

  a_r4_flat_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flat |-> out_mask);

  a_r8_outer_kept: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_line[LO_W-1:0] == sh2[LO_W-1:0])
               && (out_line[LINE_W-1:HI_B] == sh2[LINE_W-1:HI_B]));

  a_r8_nomask_pass: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_mask |-> out_line == sh2);

  a_r9_flat_pass: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flat |-> out_line == sh2);

  a_r7_hev_keeps_p1q1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_hev |-> (out_line[OP1 +: PIX_W] == sh2[OP1 +: PIX_W])
                          && (out_line[OQ1 +: PIX_W] == sh2[OQ1 +: PIX_W]));

endmodule

bind dbf_edge_filter dbf_edge_filter_chk #(.PIX_W(PIX_W), .TAPS(TAPS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_line   (in_line),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_line  (out_line),
  .out_mask  (out_mask),
  .out_hev   (out_hev),
  .out_flat  (out_flat)
);

// File: tb/sim_dbf_edge_filter.sv
module sim_dbf_edge_filter;

  localparam int NV = 10;

  // Stimulus: line bytes {q3,q2,q1,q0,p0,p1,p2,p3}
  localparam logic [63:0] VIN [NV] = '{
    64'h6464646464646464,  // 0 flat, wide
    64'h6464646464646464,  // 1 flat, narrow
    64'h6E6E6E6E64646464,  // 2 step +10, wide (flat)
    64'h6E6E6E6E64646464,  // 3 step +10, narrow
    64'h6E6E6E6E64646464,  // 4 step, edge limit too small
    64'hC8C8C8C800000000,  // 5 doubled edge diff saturates
    64'hFFFFFFFF00000000,  // 6 full swing
    64'h6E6E6E646E646464,  // 7 high variance
    64'h6E6E6E6E64646464,  // 8 flat but mask fails
    64'h646464646E6E6E6E   // 9 step -10, narrow
  };
  // Config {narrow, H, I, E}
  localparam logic [24:0] VCFG [NV] = '{
    {1'b0, 8'h05, 8'h0A, 8'h0A},
    {1'b1, 8'h05, 8'h0A, 8'h0A},
    {1'b0, 8'h05, 8'h0A, 8'h1E},
    {1'b1, 8'h05, 8'h0A, 8'h1E},
    {1'b1, 8'h05, 8'h0A, 8'h13},
    {1'b1, 8'h00, 8'h00, 8'hC8},
    {1'b1, 8'h00, 8'h00, 8'hFF},
    {1'b0, 8'h05, 8'h14, 8'h28},
    {1'b0, 8'h05, 8'h0A, 8'h13},
    {1'b1, 8'h05, 8'h0A, 8'h1E}
  };
  // Expected {line, mask, hev, flat}
  localparam logic [66:0] VEXP [NV] = '{
    {64'h6464646464646464, 3'b101},
    {64'h6464646464646464, 3'b100},
    {64'h6E6E6E6E64646464, 3'b101},
    {64'h6E6E6C6A68666464, 3'b100},
    {64'h6E6E6E6E64646464, 3'b000},
    {64'hC8C8C8C800000000, 3'b000},
    {64'hFFFFF7F00F080000, 3'b100},
    {64'h6E6E6E6969646464, 3'b110},
    {64'h6E6E6E6E64646464, 3'b000},
    {64'h646466686A6C6E6E, 3'b100}
  };
  localparam string VREQ [NV] = '{"R4", "R5", "R9", "R6 R7", "R2 R8",
                                  "R2", "R6 R7", "R3 R6", "R4 R8", "R6 R7"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_line = '0;
  logic [7:0]  lim_edge = '0, lim_inner = '0, thr_var = '0;
  logic        narrow_only = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_line;
  logic        out_mask, out_hev, out_flat;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  dbf_edge_filter u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_line(in_line), .lim_edge(lim_edge), .lim_inner(lim_inner),
    .thr_var(thr_var), .narrow_only(narrow_only), .out_valid(out_valid),
    .out_ready(out_ready), .out_line(out_line), .out_mask(out_mask),
    .out_hev(out_hev), .out_flat(out_flat)
  );

  task automatic check(input bit ok, input string req, input logic [66:0] act,
                       input logic [66:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input int v);
    in_valid    = 1'b1;
    in_line     = VIN[v];
    narrow_only = VCFG[v][24];
    thr_var     = VCFG[v][23:16];
    lim_inner   = VCFG[v][15:8];
    lim_edge    = VCFG[v][7:0];
  endtask

  task automatic check_out(input int v);
    logic [66:0] act;
    act = {out_line, out_mask, out_hev, out_flat};
    check(out_valid && act == VEXP[v], VREQ[v], act, VEXP[v]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int got;
    // R11: reset state
    repeat (3) @(negedge clk);
    check(!out_valid, "R11", {66'd0, out_valid}, 67'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready && !out_valid, "R11", {65'd0, in_ready, out_valid}, 67'd2);

    // Table walk, one line at a time: R1 latency of two edges
    for (int v = 0; v < NV; v++) begin
      drive(v);
      @(negedge clk);
      in_valid = 1'b0;
      check(!out_valid, "R1", {66'd0, out_valid}, 67'd0);
      @(negedge clk);
      check_out(v);
      @(negedge clk);
    end

    // R1: back-to-back stream, one line per cycle, in order
    got = 0;
    for (int j = 0; j < NV + 2; j++) begin
      if (j >= 2) begin
        check(out_valid, "R1", {66'd0, out_valid}, 67'd1);
        if (out_valid) begin
          check_out(got);
          got++;
        end
      end
      if (j < NV) drive(j);
      else        in_valid = 1'b0;
      @(negedge clk);
    end
    check(got == NV && !out_valid, "R1", 67'(got), 67'(NV));

    // R10: stall holds output and blocks input, then drains in order
    out_ready = 1'b0;
    drive(3);
    @(negedge clk);
    drive(6);
    @(negedge clk);
    check(!in_ready, "R10", {66'd0, in_ready}, 67'd0);
    check_out(3);
    drive(9);
    @(negedge clk);
    @(negedge clk);
    check(!in_ready, "R10", {66'd0, in_ready}, 67'd0);
    check_out(3);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_out(6);
    @(negedge clk);
    check_out(9);
    @(negedge clk);
    check(!out_valid, "R10", {66'd0, out_valid}, 67'd0);

    // R11: reset mid-stream clears the output
    drive(0);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(!out_valid, "R11", {66'd0, out_valid}, 67'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!out_valid, "R11", {66'd0, out_valid}, 67'd0);

    finish_run();
  end

endmodule